// File: doc/BRIEF.md
# Five-Level Third-Order Noise Shaper

This block is the digital requantizer of an audio playback path. It accepts signed 16-bit PCM words that an upstream 8x interpolator has already raised to 64 times the audio sample rate. Each word becomes one of five output amplitude levels, coded 0 to 4. A third-order error-feedback loop pushes the requantization noise out of the audio band. The block runs from a clock at 256 times the sample rate, so four clock cycles are available for each modulator update. The loop state advances only when a sample is accepted, so the upstream strobe sets the modulator rate.

Both edges are valid/ready streams. A single output register holds the current code. A new sample is accepted when the register is empty or is being drained in the same cycle. While the consumer holds off with `out_ready` low, the code is frozen and no input is taken. The loop state therefore never advances past an unconsumed result. Internal sums and errors saturate at the accumulator width, so an overloaded loop cannot wrap around and turn unstable.

Top module: `nsh5_modulator`

## Requirements
- R1: `out_code` is always in the range 0 to 4. Code k stands for the level (k-2)/2 of full scale, which is (k-2)*16384 in input LSBs (code 0 = -32768, code 2 = 0, code 4 = +32768).
- R2: The quantizer picks the code q+2, where q = floor((v+8192)/16384) clamped to [-2, 2]. For a loop input v, a value exactly halfway between two levels rounds upward.
- R3: For each accepted sample x[n], the loop input is v[n] = x[n] - 3e[n-1] + 3e[n-2] - e[n-3]. Here e = level - v, which gives the noise transfer (1 - z^-1)^3. The error history shifts only on accepted samples.
- R4: v and e are each saturated to the signed ACC_W-bit range (default 24 bits, [-8388608, 8388607]) rather than wrapping.
- R5: While reset (`rst_n` low) is active, the block clears all three error registers, drives `out_code` to 2 and clears `out_valid`.
- R6: From a cleared state, a stream of zero samples produces code 2 on every output.
- R7: `in_ready` is high when `out_valid` is low or `out_ready` is high. A sample accepted on a clock edge makes its code appear with `out_valid` high after that edge.
- R8: While `out_valid` is high and `out_ready` is low, `out_code` and `out_valid` hold, and no input is accepted.
- R9: For a constant input of 4096 held over 512 samples, the mean output level is within 2048 of the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 256x the audio sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_sample | input | IN_W | Signed oversampled PCM word |
| out_valid | output | 1 | `out_code` holds an unconsumed result |
| out_ready | input | 1 | Consumer takes the code this cycle |
| out_code | output | 3 | Level code, 0 to 4, 2 is mid-scale |

## Verification
The bound checker watches the handshake and the code on every cycle. It checks the code range, the reset state and acceptance leading to `out_valid`. It checks that the code and valid are frozen under back-pressure, and that an idle loop with a zero input yields the mid code. The arithmetic of the loop cannot be seen by a single-cycle property: the rounding thresholds, the exact third-order feedback, saturation under sustained full-scale drive and the DC average. The bench scenarios show these by comparing every code against an integer model of R2 to R4, and by measuring the mean level over a long constant run.

// File: rtl/nsh5_pkg.sv
package nsh5_pkg;
  localparam int ORDER = 3;
  typedef logic [2:0] code_t;
  localparam code_t CODE_MID = 3'd2;
  localparam code_t CODE_MAX = 3'd4;
endpackage

// File: rtl/nsh5_loop_filter.sv
module nsh5_loop_filter #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 24
) (
  input  logic signed [IN_W-1:0]  x_in,
  input  logic signed [ACC_W-1:0] err_d1,
  input  logic signed [ACC_W-1:0] err_d2,
  input  logic signed [ACC_W-1:0] err_d3,
  output logic signed [ACC_W-1:0] loop_v
);
  localparam int SUM_W = ACC_W + 4;
  localparam logic signed [SUM_W-1:0] V_MAX = {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] V_MIN = ~V_MAX;

  logic signed [SUM_W-1:0] xw, e1w, e2w, e3w, sum_w;

  always_comb begin
    xw  = {{(SUM_W-IN_W){x_in[IN_W-1]}}, x_in};
    e1w = {{(SUM_W-ACC_W){err_d1[ACC_W-1]}}, err_d1};
    e2w = {{(SUM_W-ACC_W){err_d2[ACC_W-1]}}, err_d2};
    e3w = {{(SUM_W-ACC_W){err_d3[ACC_W-1]}}, err_d3};
    // (1 - z^-1)^3 error feedback: -3, +3, -1 taps
    sum_w = xw - ((e1w <<< 1) + e1w) + ((e2w <<< 1) + e2w) - e3w;
    if (sum_w > V_MAX)      loop_v = V_MAX[ACC_W-1:0];
    else if (sum_w < V_MIN) loop_v = V_MIN[ACC_W-1:0];
    else                    loop_v = sum_w[ACC_W-1:0];
  end
endmodule

// File: rtl/nsh5_quantizer.sv
module nsh5_quantizer
  import nsh5_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int ACC_W = 24
) (
  input  logic signed [ACC_W-1:0] loop_v,
  output code_t                   code,
  output logic signed [ACC_W-1:0] q_err
);
  localparam int STEP_SH = IN_W - 2;
  localparam int XW = ACC_W + 2;
  localparam logic signed [XW-1:0] HALF  = XW'(1) <<< (IN_W - 3);
  localparam logic signed [XW-1:0] Q_HI  = XW'(2);
  localparam logic signed [XW-1:0] Q_LO  = -XW'(2);
  localparam logic signed [XW-1:0] E_MAX = {{(XW-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [XW-1:0] E_MIN = ~E_MAX;

  logic signed [XW-1:0] vw, q_raw, level, diff;
  logic signed [2:0]    q_cl;

  always_comb begin
    vw    = {{(XW-ACC_W){loop_v[ACC_W-1]}}, loop_v};
    q_raw = (vw + HALF) >>> STEP_SH;
    if (q_raw > Q_HI)      q_cl = 3'sd2;
    else if (q_raw < Q_LO) q_cl = -3'sd2;
    else                   q_cl = q_raw[2:0];
    code  = code_t'(q_cl) + CODE_MID;
    level = {{(XW-3){q_cl[2]}}, q_cl} <<< STEP_SH;
    diff  = level - vw;
    if (diff > E_MAX)      q_err = E_MAX[ACC_W-1:0];
    else if (diff < E_MIN) q_err = E_MIN[ACC_W-1:0];
    else                   q_err = diff[ACC_W-1:0];
  end
endmodule

// File: rtl/nsh5_err_line.sv
module nsh5_err_line #(
  parameter int ACC_W = 24,
  parameter int TAPS  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       shift_en,
  input  logic [ACC_W-1:0]           err_in,
  output logic [TAPS-1:0][ACC_W-1:0] taps
);
  genvar g;
  generate
    for (g = 0; g < TAPS; g++) begin : g_stage
      logic [ACC_W-1:0] d;
      if (g == 0) begin : g_head
        assign d = err_in;
      end else begin : g_body
        assign d = taps[g-1];
      end
      always_ff @(posedge clk) begin
        if (!rst_n)        taps[g] <= '0;
        else if (shift_en) taps[g] <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/nsh5_modulator.sv
module nsh5_modulator
  import nsh5_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int ACC_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IN_W-1:0] in_sample,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [2:0]      out_code
);
  logic                        accept;
  logic signed [ACC_W-1:0]     loop_v, q_err;
  code_t                       q_code;
  logic [ORDER-1:0][ACC_W-1:0] err_taps;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  nsh5_loop_filter #(.IN_W(IN_W), .ACC_W(ACC_W)) filt_i (
    .x_in   ($signed(in_sample)),
    .err_d1 ($signed(err_taps[0])),
    .err_d2 ($signed(err_taps[1])),
    .err_d3 ($signed(err_taps[2])),
    .loop_v (loop_v)
  );

  nsh5_quantizer #(.IN_W(IN_W), .ACC_W(ACC_W)) quant_i (
    .loop_v (loop_v),
    .code   (q_code),
    .q_err  (q_err)
  );

  nsh5_err_line #(.ACC_W(ACC_W), .TAPS(ORDER)) hist_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (accept),
    .err_in   (q_err),
    .taps     (err_taps)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= CODE_MID;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_code  <= q_code;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/nsh5_modulator_chk.sv
module nsh5_modulator_chk #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 24
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [IN_W-1:0]        in_sample,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [2:0]             out_code,
  input logic [3*ACC_W-1:0]     e_taps
);
  assert_code_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_code <= 3'd4);

  assert_reset_state_R5: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_code == 3'd2));

  assert_zero_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sample == '0 && e_taps == '0) |=> out_code == 3'd2);

  assert_accept_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));

  assert_no_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind nsh5_modulator nsh5_modulator_chk #(.IN_W(IN_W), .ACC_W(ACC_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sample (in_sample),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_code  (out_code),
  .e_taps    (err_taps)
);

// File: tb/nsh5_modulator_tb_top.sv
module nsh5_modulator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_sample = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_code;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  longint me1, me2, me3;

  always #2 clk = ~clk;

  nsh5_modulator dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; fails++;
      $display("FAIL watchdog R7: cycles %0d expected below %0d", cyc, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sat24(input longint a);
    if (a > 64'sd8388607) return 64'sd8388607;
    if (a < -64'sd8388608) return -64'sd8388608;
    return a;
  endfunction

  // Integer model of R2, R3, R4
  function automatic int model_step(input int x);
    longint v, q, e;
    v = sat24(longint'(x) - 3*me1 + 3*me2 - me3);
    q = (v + 8192) >>> 14;
    if (q > 2) q = 2;
    if (q < -2) q = -2;
    e = sat24(q*16384 - v);
    me3 = me2; me2 = me1; me1 = e;
    return int'(q) + 2;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    me1 = 0; me2 = 0; me3 = 0;
    check(out_code == 3'd2, "R5 code", out_code, 2);
    check(out_valid == 1'b0, "R5 valid", out_valid, 0);
    rst_n = 1'b1;
  endtask

  task automatic send(input int x, output int code);
    @(negedge clk);
    in_valid = 1'b1; in_sample = x[15:0];
    @(negedge clk);
    in_valid = 1'b0;
    code = out_code;
    check(out_valid == 1'b1, "R7 valid after accept", out_valid, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic send_cmp(input int x, input string req);
    int c, e;
    e = model_step(x);
    send(x, c);
    check(c == e, req, c, e);
    check(c <= 4, "R1 range", c, 4);
  endtask

  task automatic t_zero();
    int c;
    do_reset();
    for (int i = 0; i < 40; i++) begin
      send(0, c);
      check(c == 2, "R6 zero input", c, 2);
    end
  endtask

  task automatic t_thresholds();
    int xs[8] = '{8191, 8192, -8192, -8193, 24575, 24576, -32768, 32767};
    int ex[8] = '{2, 3, 2, 1, 3, 4, 0, 4};
    int c;
    for (int i = 0; i < 8; i++) begin
      do_reset();
      send(xs[i], c);
      check(c == ex[i], "R2 threshold", c, ex[i]);
    end
  endtask

  task automatic t_pattern();
    int x;
    do_reset();
    x = -30000;
    for (int i = 0; i < 300; i++) begin
      send_cmp(x, "R3 mixed pattern");
      x = x + 997;
      if (x > 30000) x = x - 60000;
    end
  endtask

  task automatic t_fullscale();
    do_reset();
    for (int i = 0; i < 200; i++) send_cmp(32767, "R4 positive overload");
    for (int i = 0; i < 200; i++) send_cmp(-32768, "R4 negative overload");
  endtask

  task automatic t_dc_average();
    longint sum, avg;
    int c, e;
    do_reset();
    sum = 0;
    for (int i = 0; i < 512; i++) begin
      e = model_step(4096);
      send(4096, c);
      check(c == e, "R3 dc run", c, e);
      sum += longint'(c - 2) * 16384;
    end
    avg = sum / 512;
    check(avg >= 2048 && avg <= 6144, "R9 dc mean", avg, 4096);
  endtask

  task automatic t_backpressure();
    int ea, eb, held;
    do_reset();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_sample = 16'd20000;
    ea = model_step(20000);
    @(negedge clk);
    in_sample = 16'hB1E0;
    check(out_valid == 1'b1, "R7 first accepted", out_valid, 1);
    check(out_code == 3'(ea), "R8 first code", out_code, ea);
    held = out_code;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R8 no accept while held", in_ready, 0);
      check(out_code == 3'(held), "R8 code held", out_code, held);
    end
    eb = model_step(-20000);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_code == 3'(eb), "R8 second sample after release", out_code, eb);
    check(out_valid == 1'b1, "R7 valid after release", out_valid, 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 drained", out_valid, 0);
  endtask

  initial begin
    me1 = 0; me2 = 0; me3 = 0;
    t_zero();
    t_thresholds();
    t_pattern();
    t_fullscale();
    t_dc_average();
    t_backpressure();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule